// File: doc/BRIEF.md
# Memory Dependence Wakeup Tracker

This block sits beside the issue logic of an out-of-order core. It holds every in-flight load, store and memory barrier in a small table, keyed by sequence number. When an operation is inserted, the tracker picks the producer that the operation must wait for. An active barrier comes first. Otherwise it uses a producing-store sequence number supplied by an external predictor. If that producer is live, the tracker records the dependency against the producer's table slot. When a store or barrier completes, its slot is freed and every operation recorded against it becomes memory-ready.

An operation is announced on the ready output once it is both register-ready and memory-ready. Whichever of the two conditions arrives last raises the announcement. Non-speculative operations and barriers never take part in the dependency check. They are announced only on an explicit command. A per-thread squash drops every entry younger than a given sequence number. The block also counts inserted loads and stores, and how many of each were given a dependency.

Top module: `memdep_tracker`

## Requirements
- R1: On a speculative insert, a load uses the load-barrier sequence number while a load barrier is active. A store uses the store-barrier sequence number while a store barrier is active. In every other case the `ins_hint_seq` value is the producer.
- R2: A producer of zero, or one that does not match a live store or barrier entry, gives no dependency. The entry is memory-ready at once, so a register-ready insert is announced one cycle after its insert edge.
- R3: `rdy_valid`/`rdy_seq` announce an entry only when it is both register-ready and memory-ready. Each entry is announced once. At most one entry is announced per cycle. When several are pending, the lowest sequence number goes first.
- R4: `ins_kind` encodes 0 = load, 1 = store, 2 = full barrier, 3 = write barrier. A full barrier arms both barrier registers with its sequence number. A write barrier arms only the store one, so loads are not held by it.
- R5: Completing a barrier disarms each barrier register only if that register holds the completing sequence number. A younger barrier stays in force.
- R6: Completing an entry frees its slot. Every entry waiting on it becomes memory-ready, and is announced if it is already register-ready.
- R7: A squash of thread T at point P removes every entry of T with sequence number greater than P. A removed entry is never announced. Entries of other threads are unaffected.
- R8: An insert with `ins_nonspec` set, and every barrier insert, skips the dependency check. Such an entry is announced only after a non-speculative-ready command, and a register-ready command does not announce it.
- R9: When all slots are live, `ins_stall` is high and an insert is dropped: nothing is stored, counted or announced.
- R10: `cnt_loads`/`cnt_stores` count accepted load and store inserts. `cnt_dep_loads`/`cnt_dep_stores` count those that were given a dependency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert an operation |
| ins_kind | input | 2 | Operation kind (see R4) |
| ins_tid | input | THREAD_W | Thread of the insert |
| ins_seq | input | SEQ_W | Sequence number of the insert |
| ins_hint_seq | input | SEQ_W | Predicted producing store, 0 for none |
| ins_regs_rdy | input | 1 | Source registers already ready at insert |
| ins_nonspec | input | 1 | Insert without a dependency check |
| ins_stall | output | 1 | Table full, insert refused |
| rr_valid | input | 1 | Register-ready command |
| rr_seq | input | SEQ_W | Target of the register-ready command |
| nsr_valid | input | 1 | Non-speculative-ready command |
| nsr_seq | input | SEQ_W | Target of the non-speculative-ready command |
| cmp_valid | input | 1 | Completion command |
| cmp_seq | input | SEQ_W | Completing sequence number |
| sq_valid | input | 1 | Squash command |
| sq_tid | input | THREAD_W | Thread to squash |
| sq_seq | input | SEQ_W | Squash point; younger entries are removed |
| rdy_valid | output | 1 | An entry is ready to issue this cycle |
| rdy_seq | output | SEQ_W | Sequence number of the ready entry |
| cnt_loads | output | CNT_W | Accepted loads |
| cnt_stores | output | CNT_W | Accepted stores |
| cnt_dep_loads | output | CNT_W | Loads given a dependency |
| cnt_dep_stores | output | CNT_W | Stores given a dependency |

## Verification
A corrupted producer index or memory-ready bit shows up in one of two ways. Either an entry is announced one cycle after an insert that should have held it, or it is never announced after its producer completes. Both are visible on the ready output within a cycle of the causing edge. A barrier register that clears on the wrong sequence number lets a store through early, and that store is announced in the wrong order. A squash that misses an entry produces an unexpected announcement as soon as that entry becomes ready. A lost slot raises `ins_stall` one insert too early.

// File: rtl/memdep_pkg.sv
package memdep_pkg;
  typedef enum logic [1:0] {
    K_LOAD    = 2'd0,
    K_STORE   = 2'd1,
    K_FULLBAR = 2'd2,
    K_WRBAR   = 2'd3
  } kind_e;

  function automatic logic is_barrier(kind_e k);
    return (k == K_FULLBAR) || (k == K_WRBAR);
  endfunction

  // Only stores and barriers may hold dependents.
  function automatic logic may_produce(kind_e k);
    return k != K_LOAD;
  endfunction
endpackage

// File: rtl/memdep_free_find.sv
module memdep_free_find #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  busy,
  output logic          full,
  output logic [IW-1:0] idx
);
  always_comb begin
    full = &busy;
    idx  = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!busy[i]) idx = IW'(i);
  end
endmodule

// File: rtl/memdep_seq_match.sv
module memdep_seq_match #(
  parameter int N  = 16,
  parameter int IW = 4,
  parameter int SW = 16
) (
  input  logic [N-1:0]         cand,
  input  logic [N-1:0][SW-1:0] seqs,
  input  logic [SW-1:0]        key,
  output logic                 hit,
  output logic [IW-1:0]        idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++)
      if (cand[i] && seqs[i] == key) begin
        hit = 1'b1;
        idx = IW'(i);
      end
  end
endmodule

// File: rtl/memdep_oldest.sv
module memdep_oldest #(
  parameter int N  = 16,
  parameter int IW = 4,
  parameter int SW = 16
) (
  input  logic [N-1:0]         req,
  input  logic [N-1:0][SW-1:0] seqs,
  output logic                 any,
  output logic [IW-1:0]        idx
);
  logic [SW-1:0] best;
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < N; i++)
      if (req[i] && (!any || seqs[i] < best)) begin
        any  = 1'b1;
        idx  = IW'(i);
        best = seqs[i];
      end
  end
endmodule

// File: rtl/memdep_tracker.sv
module memdep_tracker
  import memdep_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int SEQ_W    = 16,
  parameter int THREAD_W = 1,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ins_valid,
  input  logic [1:0]          ins_kind,
  input  logic [THREAD_W-1:0] ins_tid,
  input  logic [SEQ_W-1:0]    ins_seq,
  input  logic [SEQ_W-1:0]    ins_hint_seq,
  input  logic                ins_regs_rdy,
  input  logic                ins_nonspec,
  output logic                ins_stall,
  input  logic                rr_valid,
  input  logic [SEQ_W-1:0]    rr_seq,
  input  logic                nsr_valid,
  input  logic [SEQ_W-1:0]    nsr_seq,
  input  logic                cmp_valid,
  input  logic [SEQ_W-1:0]    cmp_seq,
  input  logic                sq_valid,
  input  logic [THREAD_W-1:0] sq_tid,
  input  logic [SEQ_W-1:0]    sq_seq,
  output logic                rdy_valid,
  output logic [SEQ_W-1:0]    rdy_seq,
  output logic [CNT_W-1:0]    cnt_loads,
  output logic [CNT_W-1:0]    cnt_stores,
  output logic [CNT_W-1:0]    cnt_dep_loads,
  output logic [CNT_W-1:0]    cnt_dep_stores
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // Table state
  logic [ENTRIES-1:0]                v_q, rr_q, mr_q, pend_q, hp_q;
  logic [ENTRIES-1:0][SEQ_W-1:0]     seq_q;
  logic [ENTRIES-1:0][THREAD_W-1:0]  tid_q;
  logic [ENTRIES-1:0][1:0]           kind_q;
  logic [ENTRIES-1:0][IW-1:0]        prod_q;
  logic                              ld_bar_on, st_bar_on;
  logic [SEQ_W-1:0]                  ld_bar_seq, st_bar_seq;

  function automatic logic [SEQ_W-1:0] producer_of(
    kind_e k, logic ldon, logic [SEQ_W-1:0] lds,
    logic ston, logic [SEQ_W-1:0] sts, logic [SEQ_W-1:0] hint);
    if (k == K_LOAD && ldon)       return lds;
    else if (k == K_STORE && ston) return sts;
    else                           return hint;
  endfunction

  // Named internal events
  logic [ENTRIES-1:0] prod_cand, sq_kill, free_now, rel, rr_cmd, nsr_cmd;
  logic               tbl_full, do_ins, ins_spec, dep_found, cmp_hit, rr_hit, nsr_hit, prod_hit;
  logic [IW-1:0]      alloc_idx, cmp_idx, rr_idx, nsr_idx, prod_idx, pick_idx;
  logic [SEQ_W-1:0]   prod_seq;
  kind_e              ins_k, cmp_k;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      prod_cand[i] = v_q[i] && may_produce(kind_e'(kind_q[i]));
      sq_kill[i]   = sq_valid && v_q[i] && tid_q[i] == sq_tid && seq_q[i] > sq_seq;
    end
  end

  memdep_free_find #(.N(ENTRIES), .IW(IW)) u_free (
    .busy(v_q), .full(tbl_full), .idx(alloc_idx));

  memdep_seq_match #(.N(ENTRIES), .IW(IW), .SW(SEQ_W)) u_cmp (
    .cand(v_q), .seqs(seq_q), .key(cmp_seq), .hit(cmp_hit), .idx(cmp_idx));
  memdep_seq_match #(.N(ENTRIES), .IW(IW), .SW(SEQ_W)) u_rr (
    .cand(v_q), .seqs(seq_q), .key(rr_seq), .hit(rr_hit), .idx(rr_idx));
  memdep_seq_match #(.N(ENTRIES), .IW(IW), .SW(SEQ_W)) u_nsr (
    .cand(v_q), .seqs(seq_q), .key(nsr_seq), .hit(nsr_hit), .idx(nsr_idx));
  memdep_seq_match #(.N(ENTRIES), .IW(IW), .SW(SEQ_W)) u_prod (
    .cand(prod_cand), .seqs(seq_q), .key(prod_seq), .hit(prod_hit), .idx(prod_idx));

  memdep_oldest #(.N(ENTRIES), .IW(IW), .SW(SEQ_W)) u_pick (
    .req(pend_q), .seqs(seq_q), .any(rdy_valid), .idx(pick_idx));

  assign ins_k     = kind_e'(ins_kind);
  assign cmp_k     = kind_e'(kind_q[cmp_idx]);
  assign ins_stall = tbl_full;
  assign rdy_seq   = seq_q[pick_idx];
  assign do_ins    = ins_valid && !tbl_full;
  assign ins_spec  = !ins_nonspec && !is_barrier(ins_k);
  assign prod_seq  = producer_of(ins_k, ld_bar_on, ld_bar_seq, st_bar_on, st_bar_seq, ins_hint_seq);

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      free_now[i] = sq_kill[i] || (cmp_valid && cmp_hit && cmp_idx == IW'(i));
      rr_cmd[i]   = rr_valid && rr_hit && rr_idx == IW'(i);
      nsr_cmd[i]  = nsr_valid && nsr_hit && nsr_idx == IW'(i);
    end
    for (int i = 0; i < ENTRIES; i++)
      rel[i] = v_q[i] && hp_q[i] && free_now[prod_q[i]] && !free_now[i];
    // A producer leaving this very cycle cannot hold a new dependent.
    dep_found = ins_spec && prod_seq != '0 && prod_hit && !free_now[prod_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0; rr_q <= '0; mr_q <= '0; pend_q <= '0; hp_q <= '0;
      seq_q <= '0; tid_q <= '0; kind_q <= '0; prod_q <= '0;
      ld_bar_on <= 1'b0; st_bar_on <= 1'b0;
      ld_bar_seq <= '0; st_bar_seq <= '0;
      cnt_loads <= '0; cnt_stores <= '0; cnt_dep_loads <= '0; cnt_dep_stores <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (do_ins && alloc_idx == IW'(i)) begin
          v_q[i]    <= 1'b1;
          seq_q[i]  <= ins_seq;
          tid_q[i]  <= ins_tid;
          kind_q[i] <= ins_kind;
          rr_q[i]   <= ins_regs_rdy;
          mr_q[i]   <= ins_spec && !dep_found;
          hp_q[i]   <= dep_found;
          prod_q[i] <= prod_idx;
          pend_q[i] <= ins_spec && !dep_found && ins_regs_rdy;
        end else if (free_now[i]) begin
          v_q[i] <= 1'b0; pend_q[i] <= 1'b0; hp_q[i] <= 1'b0;
        end else if (v_q[i]) begin
          if (rel[i])    begin mr_q[i] <= 1'b1; hp_q[i] <= 1'b0; end
          if (rr_cmd[i]) rr_q[i] <= 1'b1;
          if (((rel[i] || rr_cmd[i]) && (rr_q[i] || rr_cmd[i]) && (mr_q[i] || rel[i]))
              || nsr_cmd[i])
            pend_q[i] <= 1'b1;
          else if (rdy_valid && pick_idx == IW'(i))
            pend_q[i] <= 1'b0;
        end
      end
      // Barrier registers: clear on matching completion, then arm on insert.
      if (cmp_valid && cmp_hit && is_barrier(cmp_k)) begin
        if (ld_bar_seq == cmp_seq) ld_bar_on <= 1'b0;
        if (st_bar_seq == cmp_seq) st_bar_on <= 1'b0;
      end
      if (do_ins && ins_k == K_FULLBAR) begin
        ld_bar_on <= 1'b1; ld_bar_seq <= ins_seq;
      end
      if (do_ins && is_barrier(ins_k)) begin
        st_bar_on <= 1'b1; st_bar_seq <= ins_seq;
      end
      if (do_ins && ins_k == K_LOAD) begin
        cnt_loads <= cnt_loads + 1'b1;
        if (dep_found) cnt_dep_loads <= cnt_dep_loads + 1'b1;
      end
      if (do_ins && ins_k == K_STORE) begin
        cnt_stores <= cnt_stores + 1'b1;
        if (dep_found) cnt_dep_stores <= cnt_dep_stores + 1'b1;
      end
    end
  end
endmodule

// File: rtl/memdep_tracker_chk.sv
module memdep_tracker_chk #(
  parameter int N  = 16,
  parameter int SW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  v_q,
  input logic [N-1:0]  pend_q,
  input logic [N-1:0]  hp_q,
  input logic          ld_bar_on,
  input logic          st_bar_on,
  input logic [SW-1:0] ld_bar_seq,
  input logic [SW-1:0] st_bar_seq,
  input logic          cmp_valid,
  input logic [SW-1:0] cmp_seq,
  input logic [CW-1:0] cnt_loads,
  input logic [CW-1:0] cnt_dep_loads
);
  AST_PEND_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~v_q) == '0); // R7
  AST_WAITER_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & hp_q) == '0); // R3
  AST_STBAR_CLEAR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_bar_on) |-> ($past(cmp_valid) && $past(cmp_seq) == $past(st_bar_seq))); // R5
  AST_LDBAR_CLEAR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ld_bar_on) |-> ($past(cmp_valid) && $past(cmp_seq) == $past(ld_bar_seq))); // R5
  AST_LOAD_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_loads == $past(cnt_loads)) || (cnt_loads == CW'($past(cnt_loads) + 1'b1))); // R10
  AST_DEP_LE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_dep_loads <= cnt_loads); // R10
endmodule

bind memdep_tracker memdep_tracker_chk #(.N(ENTRIES), .SW(SEQ_W), .CW(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .v_q(v_q), .pend_q(pend_q), .hp_q(hp_q),
  .ld_bar_on(ld_bar_on), .st_bar_on(st_bar_on),
  .ld_bar_seq(ld_bar_seq), .st_bar_seq(st_bar_seq),
  .cmp_valid(cmp_valid), .cmp_seq(cmp_seq),
  .cnt_loads(cnt_loads), .cnt_dep_loads(cnt_dep_loads));

// File: tb/memdep_tracker_tb.sv
module memdep_tracker_tb_top;
  localparam int N = 16;
  localparam int SW = 16;
  localparam int TW = 1;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic ins_valid = 0, ins_regs_rdy = 0, ins_nonspec = 0;
  logic [1:0] ins_kind = 0;
  logic [TW-1:0] ins_tid = 0, sq_tid = 0;
  logic [SW-1:0] ins_seq = 0, ins_hint_seq = 0, rr_seq = 0, nsr_seq = 0, cmp_seq = 0, sq_seq = 0;
  logic rr_valid = 0, nsr_valid = 0, cmp_valid = 0, sq_valid = 0;
  logic ins_stall, rdy_valid;
  logic [SW-1:0] rdy_seq;
  logic [CW-1:0] cnt_loads, cnt_stores, cnt_dep_loads, cnt_dep_stores;

  memdep_tracker #(.ENTRIES(N), .SEQ_W(SW), .THREAD_W(TW), .CNT_W(CW)) dut_i (.*);

  int checks = 0, fails = 0;
  int e_ld = 0, e_st = 0, e_dld = 0, e_dst = 0;
  int exp_q[$];
  string tag_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_rdy(input int s, input string req);
    exp_q.push_back(s);
    tag_q.push_back(req);
  endtask

  // Monitor: every announcement must match the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && rdy_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R3/R7/R8 unexpected ready", int'(rdy_seq), -1);
      else begin
        string t;
        int e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(int'(rdy_seq) == e, t, int'(rdy_seq), e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ins(input int k, input int t, input int s, input int h,
                     input bit rdy, input bit ns, input bit acc, input bit dep);
    @(negedge clk);
    ins_valid = 1; ins_kind = 2'(k); ins_tid = TW'(t); ins_seq = SW'(s);
    ins_hint_seq = SW'(h); ins_regs_rdy = rdy; ins_nonspec = ns;
    if (acc && k == 0) begin e_ld++; if (dep) e_dld++; end
    if (acc && k == 1) begin e_st++; if (dep) e_dst++; end
    @(negedge clk);
    ins_valid = 0; ins_nonspec = 0; ins_regs_rdy = 0;
  endtask

  task automatic rr(input int s);
    @(negedge clk); rr_valid = 1; rr_seq = SW'(s);
    @(negedge clk); rr_valid = 0;
  endtask
  task automatic nsr(input int s);
    @(negedge clk); nsr_valid = 1; nsr_seq = SW'(s);
    @(negedge clk); nsr_valid = 0;
  endtask
  task automatic cmp(input int s);
    @(negedge clk); cmp_valid = 1; cmp_seq = SW'(s);
    @(negedge clk); cmp_valid = 0;
  endtask
  task automatic squash(input int t, input int s);
    @(negedge clk); sq_valid = 1; sq_tid = TW'(t); sq_seq = SW'(s);
    @(negedge clk); sq_valid = 0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    chk(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    // Reset state
    chk(!rdy_valid && !ins_stall, "R3 reset outputs", int'({rdy_valid, ins_stall}), 0);
    chk(cnt_loads == 0 && cnt_stores == 0, "R10 reset counters", int'(cnt_loads + cnt_stores), 0);

    // R2: no producer, register-ready -> announced at once
    expect_rdy(10, "R2 no-dep load");
    ins(0, 0, 10, 0, 1, 0, 1, 0);
    idle(2); cmp(10);

    // R6: load waits on a live store, woken by its completion
    expect_rdy(20, "R2 store no dep");
    ins(1, 0, 20, 0, 1, 0, 1, 0);
    ins(0, 0, 21, 20, 1, 0, 1, 1);
    idle(3);
    expect_rdy(21, "R6 wake on store completion");
    cmp(20); idle(2); cmp(21);

    // R2: hint to an absent producer means no dependency
    expect_rdy(23, "R2 absent producer");
    ins(0, 0, 23, 99, 1, 0, 1, 0);
    idle(2); cmp(23);

    // R3: memory-ready first, register-ready second
    ins(1, 0, 30, 0, 0, 0, 1, 0);
    ins(0, 0, 31, 30, 0, 0, 1, 1);
    cmp(30); idle(3);
    expect_rdy(31, "R3 register-ready arrives last");
    rr(31); idle(2); cmp(31);

    // R4/R1: full barrier holds both a load and a store, release oldest-first
    ins(2, 0, 40, 0, 0, 0, 1, 0);
    idle(2);
    expect_rdy(40, "R8 barrier on nonspec-ready");
    nsr(40);
    ins(0, 0, 41, 0, 1, 0, 1, 1);
    ins(1, 0, 42, 0, 1, 0, 1, 1);
    idle(3);
    expect_rdy(41, "R1 load held by barrier");
    expect_rdy(42, "R3 oldest-first after barrier");
    cmp(40); idle(4); cmp(41); cmp(42);

    // R5/R4: write barriers; a newer one stays in force; loads pass
    ins(3, 0, 50, 0, 0, 0, 1, 0);
    ins(3, 0, 52, 0, 0, 0, 1, 0);
    cmp(50);
    ins(1, 0, 53, 0, 1, 0, 1, 1);
    expect_rdy(54, "R4 write barrier does not hold loads");
    ins(0, 0, 54, 0, 1, 0, 1, 0);
    idle(3);
    expect_rdy(53, "R5 store held by newer write barrier");
    cmp(52); idle(2); cmp(53); cmp(54);

    // R7: squash of thread 1 only
    ins(1, 0, 60, 0, 0, 0, 1, 0);
    ins(0, 1, 61, 60, 1, 0, 1, 1);
    ins(0, 1, 62, 0, 0, 0, 1, 0);
    ins(0, 0, 65, 0, 0, 0, 1, 0);
    squash(1, 60);
    cmp(60); rr(62); idle(3);
    expect_rdy(65, "R7 other thread survives squash");
    rr(65); idle(2); cmp(65);

    // R8: non-speculative insert ignores register-ready
    ins(0, 0, 70, 0, 1, 1, 1, 0);
    rr(70); idle(3);
    expect_rdy(70, "R8 nonspec on explicit command");
    nsr(70); idle(2); cmp(70);

    // R9: fill the table
    for (int i = 0; i < N; i++) ins(0, 0, 100 + i, 0, 0, 1, 1, 0);
    chk(ins_stall, "R9 stall when full", int'(ins_stall), 1);
    ins(0, 0, 200, 0, 1, 0, 0, 0);
    idle(3);
    chk(int'(cnt_loads) == e_ld, "R9 refused insert not counted", int'(cnt_loads), e_ld);
    cmp(100);
    chk(!ins_stall, "R9 stall drops after free", int'(ins_stall), 0);
    expect_rdy(116, "R9 insert after free");
    ins(0, 0, 116, 0, 1, 0, 1, 0);
    idle(4);

    // R10: counters
    chk(int'(cnt_loads) == e_ld, "R10 loads", int'(cnt_loads), e_ld);
    chk(int'(cnt_stores) == e_st, "R10 stores", int'(cnt_stores), e_st);
    chk(int'(cnt_dep_loads) == e_dld, "R10 dependent loads", int'(cnt_dep_loads), e_dld);
    chk(int'(cnt_dep_stores) == e_dst, "R10 dependent stores", int'(cnt_dep_stores), e_dst);
    chk(exp_q.size() == 0, "R3 all expected announcements seen", exp_q.size(), 0);
    finish_run();
  end
endmodule